// File: doc/BRIEF.md
# Vector Byte and Bit-Range Mask Generator

This block produces a 128-bit constant vector in one of two ways. In byte-mask mode, a 16-bit immediate is expanded so that every immediate bit decides whether one byte of the vector is all ones or all zeros. In bit-range mode, a contiguous run of ones is built inside a single element of a selected width, and that element pattern is copied across the whole vector. The run may wrap through the element boundary.

An operation is requested by asserting `valid_i` for one cycle with the operands. The result appears on `vec_o` one cycle later, together with a single-cycle `done_o` pulse. A bit-range request with an unsupported element-size code does not update the vector. Instead, it raises `spec_err_o` alongside `done_o`.

Top module: `vmask_gen`

## Requirements
- R1: In byte-mask mode (`op_i`=0), immediate bit j controls vector byte j, meaning `vec_o[8j+7:8j]`, for j = 0..15. A set bit makes that byte 8'hFF and a clear bit makes it 8'h00. Bits 15..8 therefore cover the upper doubleword and bits 7..0 cover the lower doubleword.
- R2: In bit-range mode (`op_i`=1), the size code selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64.
- R3: A bit-range request whose size code is above 3 sets `spec_err_o` for one cycle together with `done_o`, and leaves `vec_o` unchanged.
- R4: In bit-range mode, start and end are each reduced to their low log2(width) bits before use, so higher bits have no effect.
- R5: Bit position p within an element is the bit at index width-1-p, so position 0 is the most significant bit. Positions from start up to and including end are set. When start equals end, exactly one bit per element is set.
- R6: When the reduced start is greater than the reduced end, the run wraps: positions start..width-1 and 0..end are set.
- R7: The element pattern is copied into every element of the 128-bit vector.
- R8: The vector and `done_o` update on the clock edge that samples `valid_i`. `done_o` is high for exactly one cycle per request. Without a request, `vec_o` holds its value and `done_o` and `spec_err_o` stay low.
- R9: While `rst_ni` is low, `vec_o`, `done_o` and `spec_err_o` are all zero.
- R10: In byte-mask mode the size code is ignored, and any code, including values above 3, gives no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe, one cycle per operation |
| op_i | input | 1 | 0 = byte mask, 1 = bit range |
| imm_i | input | 16 | Byte-mask immediate |
| start_i | input | 8 | Bit-range start position |
| end_i | input | 8 | Bit-range end position |
| size_i | input | 4 | Element-size code |
| vec_o | output | 128 | Generated vector |
| done_o | output | 1 | Result-valid pulse |
| spec_err_o | output | 1 | Unsupported size code in bit-range mode |

## Verification
The hardest situations to reach are the wrap-around runs in wide elements where the unreduced operands look harmless. An example is a start of 40 and an end of 35 at 32-bit width: after reduction these become 8 and 3, so the run wraps. Random start and end bytes across all four sizes reach these cases, and each result is compared with a bench loop model that steps bit by bit modulo the width. Directed table entries pin down single-bit runs, full-width runs, and byte masks whose two immediate halves are equal. An error request placed right after a known result shows that the vector is held.

// File: rtl/vmask_pkg.sv
`timescale 1ns/1ps
package vmask_pkg;
  localparam int VEC_W   = 128;
  localparam int IMM_W   = 16;
  localparam int POS_W   = 8;
  localparam int SZ_W    = 4;
  localparam int N_SIZES = 4;
  localparam int MIN_EW  = 8;

  typedef enum logic {
    OP_BYTE  = 1'b0,
    OP_RANGE = 1'b1
  } op_e;
endpackage

// File: rtl/vmask_byte_exp.sv
`timescale 1ns/1ps
module vmask_byte_exp #(
  parameter int VEC_W = 128,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  output logic [VEC_W-1:0] vec_o
);
  localparam int LANE_W = VEC_W / IMM_W;

  for (genvar i = 0; i < IMM_W; i++) begin : g_lane
    assign vec_o[i*LANE_W +: LANE_W] = {LANE_W{imm_i[i]}};
  end
endmodule

// File: rtl/vmask_range_elem.sv
`timescale 1ns/1ps
module vmask_range_elem #(
  parameter int ELEM_W = 8,
  localparam int LW    = $clog2(ELEM_W)
) (
  input  logic [LW-1:0]     start_i,
  input  logic [LW-1:0]     end_i,
  output logic [ELEM_W-1:0] pat_o
);
  logic wrap;
  assign wrap = start_i > end_i;

  // position p counts from the MSB
  for (genvar p = 0; p < ELEM_W; p++) begin : g_pos
    localparam logic [LW-1:0] POS = LW'(p);
    logic ge_s, le_e;
    assign ge_s = POS >= start_i;
    assign le_e = POS <= end_i;
    assign pat_o[ELEM_W-1-p] = wrap ? (ge_s | le_e) : (ge_s & le_e);
  end
endmodule

// File: rtl/vmask_gen.sv
`timescale 1ns/1ps
module vmask_gen
  import vmask_pkg::*;
#(
  parameter int VW    = VEC_W,
  parameter int IW    = IMM_W,
  parameter int PW    = POS_W,
  parameter int SW    = SZ_W,
  parameter int NSZ   = N_SIZES,
  localparam int SIDX = $clog2(NSZ)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          op_i,
  input  logic [IW-1:0] imm_i,
  input  logic [PW-1:0] start_i,
  input  logic [PW-1:0] end_i,
  input  logic [SW-1:0] size_i,
  output logic [VW-1:0] vec_o,
  output logic          done_o,
  output logic          spec_err_o
);
  logic [VW-1:0] byte_vec;
  logic [VW-1:0] rng_vec [NSZ];
  logic [VW-1:0] vec_d;
  logic          size_ok, err_d;

  vmask_byte_exp #(.VEC_W(VW), .IMM_W(IW)) u_byte (
    .imm_i (imm_i),
    .vec_o (byte_vec)
  );

  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int EW = MIN_EW << k;
    localparam int LW = $clog2(EW);
    logic [EW-1:0] pat;
    vmask_range_elem #(.ELEM_W(EW)) u_elem (
      .start_i (start_i[LW-1:0]),
      .end_i   (end_i[LW-1:0]),
      .pat_o   (pat)
    );
    assign rng_vec[k] = {(VW/EW){pat}};
  end

  assign size_ok = size_i < SW'(NSZ);
  assign err_d   = (op_i == OP_RANGE) && !size_ok;
  assign vec_d   = (op_i == OP_RANGE) ? rng_vec[size_i[SIDX-1:0]] : byte_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o      <= '0;
      done_o     <= 1'b0;
      spec_err_o <= 1'b0;
    end else begin
      done_o     <= valid_i;
      spec_err_o <= valid_i && err_d;
      if (valid_i && !err_d) vec_o <= vec_d;
    end
  end

  assert_done_follows_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o && !spec_err_o && $stable(vec_o));
  assert_err_holds_vec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i && (size_i > 4'd3) |=> spec_err_o && done_o && $stable(vec_o));
  assert_byte_no_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !op_i |=> !spec_err_o);
  assert_byte_lane0_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !op_i |=> vec_o[7:0] == {8{$past(imm_i[0])}});
  assert_single_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i && size_i == 4'd0 && ((start_i % 8) == (end_i % 8))
    |=> $countones(vec_o) == 16);
  assert_replicate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i && size_i == 4'd1 |=> vec_o[VW-1 -: 16] == vec_o[15:0]);
endmodule

// File: tb/tb_vmask_gen.sv
`timescale 1ns/1ps
module tb_vmask_gen;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         op_i = 1'b0;
  logic [15:0]  imm_i = '0;
  logic [7:0]   start_i = '0;
  logic [7:0]   end_i = '0;
  logic [3:0]   size_i = '0;
  logic [127:0] vec_o;
  logic         done_o, spec_err_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vmask_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i), .imm_i(imm_i),
    .start_i(start_i), .end_i(end_i), .size_i(size_i),
    .vec_o(vec_o), .done_o(done_o), .spec_err_o(spec_err_o)
  );

  // {op, imm, start, end, size, vec, err}
  localparam int NT = 9;
  localparam logic [165:0] TBL [NT] = '{
    {1'b0, 16'h0000, 8'd0, 8'd0, 4'd0, 128'h0, 1'b0},
    {1'b0, 16'hFFFF, 8'd0, 8'd0, 4'd0, {128{1'b1}}, 1'b0},
    {1'b0, 16'h8001, 8'd0, 8'd0, 4'd0, 128'hFF0000000000000000000000000000FF, 1'b0},
    {1'b0, 16'h5A5A, 8'd0, 8'd0, 4'd0, 128'h00FF00FFFF00FF0000FF00FFFF00FF00, 1'b0},
    {1'b1, 16'h0000, 8'd0, 8'd0, 4'd0, {16{8'h80}}, 1'b0},
    {1'b1, 16'h0000, 8'd6, 8'd1, 4'd0, {16{8'hC3}}, 1'b0},
    {1'b1, 16'h0000, 8'd0, 8'd63, 4'd3, {128{1'b1}}, 1'b0},
    {1'b1, 16'h0000, 8'd40, 8'd35, 4'd2, {4{32'hF0FFFFFF}}, 1'b0},
    {1'b1, 16'h0000, 8'd4, 8'd11, 4'd1, {8{16'h0FF0}}, 1'b0}
  };

  function automatic logic [127:0] ref_byte(logic [15:0] imm);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = {8{imm[i]}};
    return r;
  endfunction

  function automatic logic [127:0] ref_range(int sz, int s, int e);
    int w = 8 << sz;
    logic [63:0] pat = '0;
    logic [127:0] r = '0;
    int i;
    s = s % w;
    e = e % w;
    i = s;
    forever begin
      pat[w-1-i] = 1'b1;
      if (i == e) break;
      i = (i + 1) % w;
    end
    for (int j = 0; j < 128 / w; j++)
      for (int b = 0; b < w; b++) r[j*w + b] = pat[b];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input logic [15:0] imm, input logic [7:0] s,
                        input logic [7:0] e, input logic [3:0] sz,
                        input logic [127:0] exp_vec, input logic exp_err, input string req);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; imm_i = imm; start_i = s; end_i = e; size_i = sz;
    @(negedge clk);
    valid_i = 1'b0;
    chk(vec_o === exp_vec, req, vec_o, exp_vec);
    chk(done_o === 1'b1 && spec_err_o === exp_err, {req, " flags"},
        {126'd0, done_o, spec_err_o}, {126'd0, 1'b1, exp_err});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 128'd0, 128'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    chk(vec_o === '0 && done_o === 1'b0 && spec_err_o === 1'b0, "R9 reset",
        {vec_o[125:0], done_o, spec_err_o}, '0);
    rst_ni = 1'b1;

    for (int t = 0; t < NT; t++) begin
      logic [165:0] en = TBL[t];
      run_op(en[165], en[164:149], en[148:141], en[140:133], en[132:129], en[128:1], en[0],
             en[165] ? "R5 R6 R7 table" : "R1 table");
    end

    // R8: done is one cycle; idle holds vector
    held = vec_o;
    @(negedge clk);
    chk(done_o === 1'b0 && vec_o === held, "R8 idle", vec_o, held);

    // R3: bad size in range mode keeps vector
    run_op(1'b0, 16'h00F0, 8'd0, 8'd0, 4'd0, ref_byte(16'h00F0), 1'b0, "R1 preload");
    run_op(1'b1, 16'h0000, 8'd2, 8'd5, 4'd7, ref_byte(16'h00F0), 1'b1, "R3 bad size");
    @(negedge clk);
    chk(spec_err_o === 1'b0 && done_o === 1'b0, "R3 err pulse", {127'd0, spec_err_o}, '0);

    // R10: byte mode ignores size
    run_op(1'b0, 16'h1234, 8'd0, 8'd0, 4'd15, ref_byte(16'h1234), 1'b0, "R10 size ignored");

    // R4: high bits of start/end ignored
    run_op(1'b1, 16'h0, 8'hF9, 8'h7B, 4'd0, ref_range(0, 1, 3), 1'b0, "R4 reduce");
    run_op(1'b1, 16'h0, 8'd5, 8'd5, 4'd3, ref_range(3, 5, 5), 1'b0, "R5 single");

    for (int n = 0; n < 300; n++) begin
      int sz = $urandom_range(3, 0);
      int s  = $urandom_range(255, 0);
      int e  = $urandom_range(255, 0);
      int w  = 8 << sz;
      run_op(1'b1, 16'h0, 8'(s), 8'(e), 4'(sz), ref_range(sz, s, e), 1'b0,
             ((s % w) > (e % w)) ? "R2 R6 wrap" : "R2 R5 run");
    end
    for (int n = 0; n < 50; n++) begin
      logic [15:0] imm = 16'($urandom);
      if (n % 5 == 0) imm = {imm[7:0], imm[7:0]};
      run_op(1'b0, imm, 8'd0, 8'd0, 4'(n), ref_byte(imm), 1'b0, "R1 random");
    end

    // R9: reset clears after activity
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(vec_o === '0 && done_o === 1'b0 && spec_err_o === 1'b0, "R9 reset again",
        vec_o, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule